// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block watches one bank of already-synchronised pin levels and turns selected conditions on each pin into interrupt events. Every pin is configured on its own to detect a high level, a low level, a rising edge, a falling edge or either edge. A detected event sets a sticky status bit. Software clears the bit by writing a one to it. A per-pin mask decides whether a latched status bit contributes to the single combined interrupt line.

The mask is never written directly. One write-only port clears mask bits for the pins whose data bits are one (unmask), and a second write-only port sets them (mask). Detection and latching run regardless of the mask. A pin that saw an event while masked therefore raises the interrupt as soon as it is unmasked, unless software clears its status first. Access is through a small single-cycle register bus with word addresses and a combinational read path.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the mask (word 3) reads all ones, status (word 6) reads zero, the trigger-kind (word 0), sense (word 1) and both-edge (word 2) registers read zero, and the interrupt output is low.
- R2: With kind bit 0 and sense bit 1 (level-high), a pin's status bit is set on every cycle the pin is high, so a status clear while the pin stays high leaves the bit set.
- R3: With kind bit 0 and sense bit 0 (level-low), a pin's status bit is set while the pin is low and is not set while it is high.
- R4: With kind bit 1, sense bit 1 and both-edge bit 0, status is set when the pin goes from 0 to 1 relative to its level in the previous cycle, and not when it goes from 1 to 0 or stays high.
- R5: With kind bit 1, sense bit 0 and both-edge bit 0, status is set on a 1-to-0 change only.
- R6: With kind bit 1 and both-edge bit 1, status is set on either change, whatever the sense bit.
- R7: Writing to word 6 clears exactly the status bits whose data bits are one; status bits written with zero keep their value.
- R8: When a detection and a status clear hit the same pin in the same cycle, the status bit ends set.
- R9: Writing to word 4 clears the mask bits whose data bits are one and leaves the others; word 4 reads as zero.
- R10: Writing to word 5 sets the mask bits whose data bits are one and leaves the others; word 5 reads as zero.
- R11: The interrupt output is high exactly when some status bit is one while its mask bit is zero; a status bit latched while masked raises the output once its pin is unmasked.
- R12: Words 0, 1 and 2 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| pin_i | input | 32 | Synchronised pin levels |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt, high when an unmasked status bit is set |

## Verification
A corrupted mask or status register shows at the ports on the very next clock edge: the word-3 and word-6 reads return it directly and irq_o follows their combination without delay. A wrong previous-level register shows as a missing or extra edge event in the cycle after the pin change, and a wrong kind or sense bit shows as a status bit that sets on a quiet pin or fails to re-set after a clear. Each scenario therefore reads the status and mask words one edge after its stimulus and compares the interrupt line against the unmasked status it expects.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the GPIO interrupt detector: bus geometry and word map.
package gpio_irq_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_KIND    = 3'd0; // 1 = edge, 0 = level
    localparam logic [ADDR_W-1:0] ADR_SENSE   = 3'd1; // 1 = high/rising
    localparam logic [ADDR_W-1:0] ADR_BOTH    = 3'd2; // 1 = either edge
    localparam logic [ADDR_W-1:0] ADR_MASK    = 3'd3; // read-only mask view
    localparam logic [ADDR_W-1:0] ADR_UNMASK  = 3'd4; // write ones to unmask
    localparam logic [ADDR_W-1:0] ADR_MASKSET = 3'd5; // write ones to mask
    localparam logic [ADDR_W-1:0] ADR_STATUS  = 3'd6; // sticky, write-one-clear
endpackage

// File: rtl/gpio_irq_cfg.sv
// Configuration store: trigger kind, sense and both-edge registers plus the
// pin mask, which only moves through the separate unmask and mask-set words.
// Assumes one write strobe per access; reset leaves every pin masked.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NPIN-1:0]   wdata_i,
    output logic [NPIN-1:0]   kind_o,
    output logic [NPIN-1:0]   sense_o,
    output logic [NPIN-1:0]   both_o,
    output logic [NPIN-1:0]   mask_o
);
    logic [NPIN-1:0] kind_q, sense_q, both_q, mask_q;

    // Holds the three read/write trigger configuration words.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            kind_q  <= '0;
            sense_q <= '0;
            both_q  <= '0;
        end else if (we_i) begin
            if (addr_i == ADR_KIND)  kind_q  <= wdata_i;
            if (addr_i == ADR_SENSE) sense_q <= wdata_i;
            if (addr_i == ADR_BOTH)  both_q  <= wdata_i;
        end
    end

    // Mask bits are cleared by the unmask word and set by the mask-set word.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mask_q <= '1;
        end else if (we_i && addr_i == ADR_UNMASK) begin
            mask_q <= mask_q & ~wdata_i;
        end else if (we_i && addr_i == ADR_MASKSET) begin
            mask_q <= mask_q | wdata_i;
        end
    end

    assign kind_o  = kind_q;
    assign sense_o = sense_q;
    assign both_o  = both_q;
    assign mask_o  = mask_q;
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin event detector. Keeps the previous-cycle level of every pin and
// raises a one-cycle hit according to that pin's kind, sense and both-edge
// bits. Assumes pin levels are already synchronised to clk_i.
module gpio_irq_detect #(
    parameter int NPIN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] kind_i,
    input  logic [NPIN-1:0] sense_i,
    input  logic [NPIN-1:0] both_i,
    output logic [NPIN-1:0] hit_o
);
    logic [NPIN-1:0] prev_q;

    // Registers each pin's level for edge comparison in the next cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= pin_i;
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic rise, fall, edge_hit, level_hit;
        // Selects the event condition this pin is configured for.
        always_comb begin
            rise      = pin_i[g] & ~prev_q[g];
            fall      = ~pin_i[g] & prev_q[g];
            level_hit = (pin_i[g] == sense_i[g]);
            if (both_i[g])       edge_hit = rise | fall;
            else if (sense_i[g]) edge_hit = rise;
            else                 edge_hit = fall;
            hit_o[g] = kind_i[g] ? edge_hit : level_hit;
        end
    end
endmodule

// File: rtl/gpio_irq_status.sv
// Sticky status and interrupt combiner. A hit sets its status bit, a
// write-one to the status word clears it, and a hit in the same cycle wins.
// The output combines status with the inverted mask; detection ignores mask.
module gpio_irq_status #(
    parameter int NPIN = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NPIN-1:0] hit_i,
    input  logic [NPIN-1:0] clr_i,
    input  logic [NPIN-1:0] mask_i,
    output logic [NPIN-1:0] status_o,
    output logic            irq_o
);
    logic [NPIN-1:0] status_q;

    // Latches events; clears only bits with no simultaneous event.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) status_q <= '0;
        else         status_q <= (status_q & ~clr_i) | hit_i;
    end

    // Single interrupt line from any unmasked pending bit.
    always_comb irq_o = |(status_q & ~mask_i);

    assign status_o = status_q;
endmodule

// File: rtl/gpio_irq_bank.sv
// Top of the GPIO interrupt detector for one bank. Decodes the register bus,
// wires the configuration store, the per-pin detector and the sticky status,
// and returns read data combinationally. Write-only words read as zero.
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPIN-1:0]   pin_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NPIN-1:0]   bus_wdata_i,
    output logic [NPIN-1:0]   bus_rdata_o,
    output logic              irq_o
);
    logic [NPIN-1:0] kind_q, sense_q, both_q, mask_q, status_q, hit, clr;

    gpio_irq_cfg #(.NPIN(NPIN)) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .kind_o  (kind_q),
        .sense_o (sense_q),
        .both_o  (both_q),
        .mask_o  (mask_q)
    );

    gpio_irq_detect #(.NPIN(NPIN)) u_det (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i),
        .kind_i  (kind_q),
        .sense_i (sense_q),
        .both_i  (both_q),
        .hit_o   (hit)
    );

    // Status clear vector: write data when the status word is written.
    always_comb clr = (bus_we_i && bus_addr_i == ADR_STATUS) ? bus_wdata_i : '0;

    gpio_irq_status #(.NPIN(NPIN)) u_sts (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hit_i    (hit),
        .clr_i    (clr),
        .mask_i   (mask_q),
        .status_o (status_q),
        .irq_o    (irq_o)
    );

    // Read mux over the word map.
    always_comb begin
        unique case (bus_addr_i)
            ADR_KIND:   bus_rdata_o = kind_q;
            ADR_SENSE:  bus_rdata_o = sense_q;
            ADR_BOTH:   bus_rdata_o = both_q;
            ADR_MASK:   bus_rdata_o = mask_q;
            ADR_STATUS: bus_rdata_o = status_q;
            default:    bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
// Property checker for gpio_irq_bank, attached by bind. Watches the bus,
// the mask and status registers, and the interrupt output.
module gpio_irq_bank_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [NPIN-1:0]   bus_wdata_i,
    input logic [NPIN-1:0]   mask_q,
    input logic [NPIN-1:0]   status_q,
    input logic [NPIN-1:0]   kind_q,
    input logic              irq_o
);
    // R9
    unmask_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == ADR_UNMASK) |=> ((mask_q & $past(bus_wdata_i)) == '0));

    // R10
    maskset_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == ADR_MASKSET)
        |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    // R7
    status_no_spurious_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_we_i && bus_addr_i == ADR_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R11
    irq_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((status_q & ~mask_q) != '0));

    // R12
    kind_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_we_i && bus_addr_i == ADR_KIND) |=> $stable(kind_q));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .mask_q      (mask_q),
    .status_q    (status_q),
    .kind_q      (kind_q),
    .irq_o       (irq_o)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;
    import gpio_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '1;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_bank dut (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pins = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 mask", ADR_MASK, 32'hFFFF_FFFF);
        rd_chk("R1 status", ADR_STATUS, 32'h0);
        rd_chk("R1 kind", ADR_KIND, 32'h0);
        rd_chk("R1 sense", ADR_SENSE, 32'h0);
        rd_chk("R1 both", ADR_BOTH, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_level_high;
        wr(ADR_SENSE, 32'h0000_0008);
        @(negedge clk);
        rd_chk("R2 level-high sets", ADR_STATUS, 32'h0000_0008);
        wr(ADR_STATUS, 32'h0000_0008);
        rd_chk("R2 clear while high re-sets", ADR_STATUS, 32'h0000_0008);
        set_pins(32'hFFFF_FFF7);
        wr(ADR_STATUS, 32'h0000_0008);
        rd_chk("R2 cleared after pin low", ADR_STATUS, 32'h0);
    endtask

    task automatic t_level_low;
        set_pins(32'hFFFF_FFD7);
        rd_chk("R3 level-low sets", ADR_STATUS, 32'h0000_0020);
        set_pins(32'hFFFF_FFF7);
        wr(ADR_STATUS, 32'h0000_0020);
        rd_chk("R3 high pin stays clear", ADR_STATUS, 32'h0);
    endtask

    task automatic t_rising;
        wr(ADR_KIND, 32'h0000_0400);
        wr(ADR_SENSE, 32'h0000_0408);
        wr(ADR_STATUS, 32'hFFFF_FFFF);
        rd_chk("R4 start clear", ADR_STATUS, 32'h0);
        set_pins(32'hFFFF_FBF7);
        rd_chk("R4 falling ignored", ADR_STATUS, 32'h0);
        set_pins(32'hFFFF_FFF7);
        rd_chk("R4 rising sets", ADR_STATUS, 32'h0000_0400);
        wr(ADR_STATUS, 32'h0000_0400);
        @(negedge clk);
        rd_chk("R4 steady high no event", ADR_STATUS, 32'h0);
    endtask

    task automatic t_falling;
        wr(ADR_SENSE, 32'h0000_0008);
        set_pins(32'hFFFF_FBF7);
        rd_chk("R5 falling sets", ADR_STATUS, 32'h0000_0400);
        wr(ADR_STATUS, 32'h0000_0400);
        set_pins(32'hFFFF_FFF7);
        rd_chk("R5 rising ignored", ADR_STATUS, 32'h0);
    endtask

    task automatic t_both;
        wr(ADR_BOTH, 32'h0000_0400);
        set_pins(32'hFFFF_FBF7);
        rd_chk("R6 falling sets", ADR_STATUS, 32'h0000_0400);
        wr(ADR_STATUS, 32'h0000_0400);
        set_pins(32'hFFFF_FFF7);
        rd_chk("R6 rising sets", ADR_STATUS, 32'h0000_0400);
    endtask

    task automatic t_clear_rules;
        wr(ADR_STATUS, 32'h0000_0000);
        rd_chk("R7 zero write keeps bit", ADR_STATUS, 32'h0000_0400);
        wr(ADR_STATUS, 32'h0000_0400);
        rd_chk("R7 one write clears bit", ADR_STATUS, 32'h0);
        // R8: edge and clear in the same cycle
        @(negedge clk);
        pins = 32'hFFFF_FBF7; we = 1'b1; addr = ADR_STATUS; wdata = 32'h0000_0400;
        @(negedge clk);
        we = 1'b0;
        rd_chk("R8 detection wins", ADR_STATUS, 32'h0000_0400);
    endtask

    task automatic t_mask;
        chk("R11 masked pending no irq", {31'b0, irq}, 32'h0);
        wr(ADR_UNMASK, 32'h0000_0400);
        rd_chk("R9 unmask clears bit", ADR_MASK, 32'hFFFF_FBFF);
        rd_chk("R9 unmask word reads zero", ADR_UNMASK, 32'h0);
        chk("R11 latched event fires on unmask", {31'b0, irq}, 32'h1);
        wr(ADR_MASKSET, 32'h0000_0400);
        rd_chk("R10 mask-set sets bit", ADR_MASK, 32'hFFFF_FFFF);
        rd_chk("R10 mask-set word reads zero", ADR_MASKSET, 32'h0);
        chk("R10 irq drops when masked", {31'b0, irq}, 32'h0);
        wr(ADR_UNMASK, 32'h0000_0401);
        rd_chk("R9 other bits untouched", ADR_MASK, 32'hFFFF_FBFE);
        chk("R11 irq on again", {31'b0, irq}, 32'h1);
        wr(ADR_STATUS, 32'h0000_0400);
        chk("R11 irq low after clear", {31'b0, irq}, 32'h0);
        wr(ADR_MASKSET, 32'h0000_0001);
        rd_chk("R10 only written bit set", ADR_MASK, 32'hFFFF_FBFF);
    endtask

    task automatic t_readback;
        rd_chk("R12 kind", ADR_KIND, 32'h0000_0400);
        rd_chk("R12 sense", ADR_SENSE, 32'h0000_0008);
        rd_chk("R12 both", ADR_BOTH, 32'h0000_0400);
        wr(ADR_KIND, 32'hA5A5_0400);
        rd_chk("R12 kind pattern", ADR_KIND, 32'hA5A5_0400);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level_high();
        t_level_low();
        t_rising();
        t_falling();
        t_both();
        t_clear_rules();
        t_mask();
        t_readback();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule